// File: doc/BRIEF.md
# Triangle Ramp Code Generator

This block drives the digital input of a resistor-ladder DAC with a repeating triangle. A single counter climbs one code at a time from zero toward a configured peak and then falls back to zero. Each code is held on the output for a programmable number of clocks. A one-clock strobe accompanies every new code, so a downstream register or a monitor can tell when the bus has moved.

Two configuration inputs set the shape of the wave. The peak input sets the height of the triangle. The hold input sets how long each code stays on the bus, and so sets the frequency. Both are captured only while reset is active and at the start of each period, which is the moment the counter returns to zero. A change in the middle of a wave therefore takes effect only on the next period. The up ramp stops one code below the peak and the down ramp starts at the peak, so one period always holds exactly twice the peak in samples.

Top module: `tri_wave_gen`

## Requirements
- R1: A synchronous active-high reset sets the sample bus to 0, keeps the strobe low and selects the rising phase. While reset is active, the current peak and hold inputs are captured for the first period.
- R2: In the rising phase the bus shows 0, 1, 2 and so on, one code higher per sample, up to the effective peak minus one.
- R3: After the code one below the effective peak, the next sample is the peak itself and the falling phase begins. The code then drops by one per sample down to 1, and the sample after 1 is 0, which starts a new rising phase. One period is 2×peak samples. A peak of 1 gives the alternating sequence 0, 1, 0, 1.
- R4: A peak input of 0 acts as 256. The internal count then reaches 256, which appears on the 8-bit bus as 255, so code 255 stays on the bus across three consecutive samples.
- R5: With an effective hold H, a rising-phase sample lasts HOLD_UNIT×H + UP_EXTRA clocks, which is 3H+4 by default. A falling-phase sample, including the peak sample, lasts HOLD_UNIT×H + DN_EXTRA clocks, which is 3H+3 by default. These times are measured from one change of the bus to the next.
- R6: A hold input of 0 acts as 256. By default a rising sample then lasts 772 clocks and a falling sample 771 clocks.
- R7: The strobe is high for exactly one clock, in the first cycle in which the bus shows a new code. The bus never changes while the strobe is low, and the strobe never rises when the code stays the same.
- R8: A change of the peak or hold input outside reset has no effect until the counter next returns to 0. The period in progress finishes with the old settings.
- R9: The internal count never exceeds the captured peak. In the rising phase it stays below the peak, and in the falling phase it never reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| peak_cfg | input | 8 | Triangle height; 0 means 256 |
| hold_cfg | input | HOLD_W | Hold count per sample; 0 means 2^HOLD_W |
| dac_code | output | 8 | Code for the resistor ladder |
| dac_strobe | output | 1 | One-clock pulse when dac_code changes |

## Verification
The bench rebuilds the expected code stream and the dwell time of every sample from its own model of the period. It compares each strobe against that model, so a turn-around placed one code early or late shows up as a wrong code, and an overhead applied to the wrong phase shows up as a wrong duration. Peaks of 1 and 0 are exercised, along with a hold of 0. A design that failed to treat 0 as 256 would produce a stalled or very short wave, and one that truncated 256 instead of clamping it would drop to 0 at the top. Settings are changed in the middle of a wave to catch a design that loads them too early. Reset is applied in the middle of a wave to catch a design that keeps old settings or a stale code.

// File: rtl/tri_wave_pkg.sv
package tri_wave_pkg;

  localparam int CW = 8;        // DAC code width
  localparam int VW = CW + 1;   // internal count width, holds 2^CW

  typedef enum logic {
    PH_UP   = 1'b0,
    PH_DOWN = 1'b1
  } ramp_ph_e;

  typedef struct packed {
    ramp_ph_e        ph;
    logic [VW-1:0]   val;
  } ramp_st_t;

  // Peak input of zero stands for the full code range.
  function automatic logic [VW-1:0] peak_span(input logic [CW-1:0] p);
    return (p == '0) ? (VW'(1) << CW) : {1'b0, p};
  endfunction

  // Internal count to bus code; the one value past the code range clamps.
  function automatic logic [CW-1:0] to_code(input logic [VW-1:0] v);
    return v[CW] ? {CW{1'b1}} : v[CW-1:0];
  endfunction

  // True when the present sample is the last one of a period.
  function automatic logic last_of_period(input ramp_st_t s);
    return (s.ph == PH_DOWN) && (s.val == VW'(1));
  endfunction

  // State of the next sample.
  function automatic ramp_st_t advance(input ramp_st_t s, input logic [VW-1:0] pk);
    ramp_st_t      n;
    logic [VW-1:0] up1;
    up1 = s.val + VW'(1);
    n   = s;
    if (s.ph == PH_UP) begin
      n.val = up1;
      n.ph  = (up1 < pk) ? PH_UP : PH_DOWN;
    end else if (last_of_period(s)) begin
      n.val = '0;
      n.ph  = PH_UP;
    end else begin
      n.val = s.val - VW'(1);
    end
    return n;
  endfunction

endpackage

// File: rtl/tri_param_hold.sv
module tri_param_hold
  import tri_wave_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              capture,
  input  logic [CW-1:0]     peak_in,
  input  logic [HOLD_W-1:0] hold_in,
  output logic [VW-1:0]     peak_q,
  output logic [HOLD_W:0]   hold_q,
  output logic [HOLD_W:0]   hold_nx
);

  // Hold input of zero stands for one full wrap of the count.
  function automatic logic [HOLD_W:0] hold_span(input logic [HOLD_W-1:0] h);
    return (h == '0) ? ((HOLD_W+1)'(1) << HOLD_W) : {1'b0, h};
  endfunction

  assign hold_nx = hold_span(hold_in);

  always_ff @(posedge clk) begin
    if (capture) begin
      peak_q <= peak_span(peak_in);
      hold_q <= hold_nx;
    end
  end

endmodule

// File: rtl/tri_dwell_timer.sv
module tri_dwell_timer #(
  parameter int HOLD_W    = 8,
  parameter int HOLD_UNIT = 3,
  parameter int UP_EXTRA  = 4,
  parameter int DN_EXTRA  = 3
) (
  input  logic            clk,
  input  logic            load,
  input  logic [HOLD_W:0] hold_len,
  input  logic            up_phase,
  output logic            expired
);

  localparam int MAX_EXTRA = (UP_EXTRA > DN_EXTRA) ? UP_EXTRA : DN_EXTRA;
  localparam int MAX_DWELL = HOLD_UNIT * (1 << HOLD_W) + MAX_EXTRA;
  localparam int DW        = $clog2(MAX_DWELL + 1);

  logic [DW-1:0] left_q;

  // Clocks one sample stays on the bus.
  function automatic logic [DW-1:0] dwell_len(input logic [HOLD_W:0] h, input logic up);
    logic [DW-1:0] base;
    base = DW'(h) * DW'(HOLD_UNIT);
    return base + (up ? DW'(UP_EXTRA) : DW'(DN_EXTRA));
  endfunction

  assign expired = (left_q == '0);

  always_ff @(posedge clk) begin
    if (load)
      left_q <= dwell_len(hold_len, up_phase) - DW'(1);
    else if (!expired)
      left_q <= left_q - DW'(1);
  end

endmodule

// File: rtl/tri_ramp_seq.sv
module tri_ramp_seq
  import tri_wave_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [VW-1:0] peak_q,
  output logic [CW-1:0] code_q,
  output logic          strobe_q,
  output logic          up_q,
  output logic [VW-1:0] val_q,
  output logic          wrap,
  output logic          nxt_up
);

  ramp_st_t st_q;
  ramp_st_t st_nx;

  assign st_nx  = advance(st_q, peak_q);
  assign wrap   = step && last_of_period(st_q);
  assign nxt_up = (st_nx.ph == PH_UP);
  assign up_q   = (st_q.ph == PH_UP);
  assign val_q  = st_q.val;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= '{ph: PH_UP, val: '0};
      code_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= step && (to_code(st_nx.val) != code_q);
      if (step) begin
        st_q   <= st_nx;
        code_q <= to_code(st_nx.val);
      end
    end
  end

endmodule

// File: rtl/tri_wave_gen.sv
module tri_wave_gen
  import tri_wave_pkg::*;
#(
  parameter int HOLD_W    = 8,
  parameter int HOLD_UNIT = 3,
  parameter int UP_EXTRA  = 4,
  parameter int DN_EXTRA  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     peak_cfg,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic [CW-1:0]     dac_code,
  output logic              dac_strobe
);

  // Named internal events, also observed by the bound checker.
  logic            step;
  logic            wrap;
  logic            capture;
  logic            ramp_up;
  logic            nxt_up;
  logic [VW-1:0]   ramp_val;
  logic [VW-1:0]   peak_q;
  logic [HOLD_W:0] hold_q;
  logic [HOLD_W:0] hold_nx;
  logic [HOLD_W:0] dwell_hold;
  logic            dwell_up;

  assign capture    = rst || wrap;
  assign dwell_hold = capture ? hold_nx : hold_q;
  assign dwell_up   = rst ? 1'b1 : nxt_up;

  tri_param_hold #(.HOLD_W(HOLD_W)) u_params (
    .clk     (clk),
    .capture (capture),
    .peak_in (peak_cfg),
    .hold_in (hold_cfg),
    .peak_q  (peak_q),
    .hold_q  (hold_q),
    .hold_nx (hold_nx)
  );

  tri_dwell_timer #(
    .HOLD_W    (HOLD_W),
    .HOLD_UNIT (HOLD_UNIT),
    .UP_EXTRA  (UP_EXTRA),
    .DN_EXTRA  (DN_EXTRA)
  ) u_timer (
    .clk      (clk),
    .load     (rst || step),
    .hold_len (dwell_hold),
    .up_phase (dwell_up),
    .expired  (step)
  );

  tri_ramp_seq u_ramp (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .peak_q   (peak_q),
    .code_q   (dac_code),
    .strobe_q (dac_strobe),
    .up_q     (ramp_up),
    .val_q    (ramp_val),
    .wrap     (wrap),
    .nxt_up   (nxt_up)
  );

endmodule

// File: rtl/tri_wave_chk.sv
module tri_wave_chk
  import tri_wave_pkg::*;
#(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] code,
  input logic          strobe,
  input logic          up,
  input logic [VW-1:0] val,
  input logic [VW-1:0] peak_q,
  input logic [HW:0]   hold_q,
  input logic          wrap
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (code == '0) && up && !strobe);

  assert_rise_below_peak_R2: assert property (@(posedge clk) disable iff (rst)
    up |-> (val < peak_q));

  assert_fall_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    !up |-> (val != '0) && (val <= peak_q));

  assert_wrap_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (val == '0) && up);

  assert_strobe_marks_change_R7: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (code != $past(code)));

  assert_quiet_bus_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> $stable(code));

  assert_strobe_one_clock_R7: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  assert_settings_held_R8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(peak_q) && $stable(hold_q));

endmodule

bind tri_wave_gen tri_wave_chk #(.HW(HOLD_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .code   (dac_code),
  .strobe (dac_strobe),
  .up     (ramp_up),
  .val    (ramp_val),
  .peak_q (peak_q),
  .hold_q (hold_q),
  .wrap   (wrap)
);

// File: tb/sim_tri_wave_gen.sv
module sim_tri_wave_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] peak_in = 8'd4;
  logic [7:0] hold_in = 8'd1;
  wire  [7:0] sample;
  wire        strobe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Bench model of the wave: effective peak, hold and position in period.
  int mP, mH, mk;

  always #4 clk = ~clk;

  tri_wave_gen u0 (
    .clk        (clk),
    .rst        (rst),
    .peak_cfg   (peak_in),
    .hold_cfg   (hold_in),
    .dac_code   (sample),
    .dac_strobe (strobe)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic model_latch();
    mP = (peak_in == 0) ? 256 : int'(peak_in);
    mH = (hold_in == 0) ? 256 : int'(hold_in);
  endtask

  function automatic int mcode(input int k);
    int c;
    c = (k <= mP) ? k : 2 * mP - k;
    return (c > 255) ? 255 : c;
  endfunction

  function automatic int mdur(input int k);
    return 3 * mH + ((k < mP) ? 4 : 3);
  endfunction

  // Waits for the next strobe; counts negedges; flags bus moves without strobe.
  task automatic wait_strobe(output int code, output int cyc, output bit bad);
    int start;
    start = sample;
    cyc   = 0;
    bad   = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (!strobe && sample != start) bad = 1;
      if (cyc == 1 && strobe) bad = 1;
    end while (!strobe && cyc < 4000);
    code = sample;
  endtask

  task automatic do_reset(input int p, input int h);
    @(negedge clk);
    peak_in = 8'(p);
    hold_in = 8'(h);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(sample == 0, "R1 code in reset", sample, 0);
    chk(strobe == 0, "R1 strobe in reset", strobe, 0);
    model_latch();
    mk  = 0;
    rst = 1'b0;
  endtask

  // Follows the wave for nstr strobes; optional setting change after chg_at.
  task automatic run_wave(input int nstr, input int chg_at, input int p2, input int h2,
                          input string tag);
    int cur, nxt, acc, got, cyc;
    bit bad;
    string ct, dt;
    cur = mcode(mk);
    for (int s = 0; s < nstr; s++) begin
      acc = 0;
      do begin
        acc += mdur(mk);
        mk++;
        if (mk == 2 * mP) begin
          mk = 0;
          model_latch();
        end
        nxt = mcode(mk);
      end while (nxt == cur);
      wait_strobe(got, cyc, bad);
      ct = (tag != "") ? tag : ((mk != 0 && mk < mP) ? "R2" : "R3");
      dt = (tag != "") ? tag : ((mH == 256) ? "R6" : "R5");
      chk(got == nxt, {ct, " code"}, got, nxt);
      chk(cyc == acc, {dt, " dwell"}, cyc, acc);
      chk(!bad, "R7 strobe/bus", int'(bad), 0);
      cur = nxt;
      if (s == chg_at) begin
        peak_in = 8'(p2);
        hold_in = 8'(h2);
      end
    end
  endtask

  task automatic t_reset();
    do_reset(4, 1);
    // still at 0 well before the first dwell ends
    repeat (3) @(negedge clk);
    chk(sample == 0, "R1 code after release", sample, 0);
    chk(strobe == 0, "R1 strobe after release", strobe, 0);
  endtask

  task automatic t_small_peak();
    do_reset(4, 1);
    run_wave(18, -1, 0, 0, "");
  endtask

  task automatic t_peak_one();
    do_reset(1, 2);
    run_wave(8, -1, 0, 0, "R3");
  endtask

  task automatic t_hold_zero();
    do_reset(2, 0);
    run_wave(5, -1, 0, 0, "R6");
  endtask

  task automatic t_peak_zero();
    do_reset(0, 1);
    run_wave(514, -1, 0, 0, "R4");
  endtask

  task automatic t_mid_change();
    do_reset(3, 1);
    run_wave(14, 1, 2, 2, "R8");
  endtask

  task automatic t_half_scale();
    do_reset(127, 1);
    run_wave(260, -1, 0, 0, "");
  endtask

  task automatic t_reset_mid_wave();
    do_reset(5, 1);
    run_wave(6, -1, 0, 0, "");
    do_reset(6, 3);
    run_wave(14, -1, 0, 0, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_small_peak();
    t_peak_one();
    t_hold_zero();
    t_peak_zero();
    t_mid_change();
    t_half_scale();
    t_reset_mid_wave();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule